// File: doc/BRIEF.md
# Program Suspend and Resume Sequencer

This block is the command-side controller that lets a host pause a byte program already running in a flash program engine, read other locations while it is paused, and then let the program continue. It receives command writes as a data byte, an address and a write strobe. It talks to an abstract program engine through four signals: a start pulse, a pause request, a paused acknowledge and a done pulse. An abort pulse abandons a paused operation.

The engine is never stopped immediately. A suspend command only raises the pause request, and the engine chooses the safe point at which it halts. Until the engine reports that it has paused, the interface shows busy. While paused, the interface accepts only three commands, and it never returns array data for the location whose program is paused. The supply-valid and reset-level qualifiers are captured when programming starts. If either one differs while the operation is suspended, the operation is abandoned and error bits are raised.

The block drives a ready/busy output, an 8-bit status byte and a read-path select. The read-path select chooses between array data (1) and status data (0).

Top module: `psq_seq`

## Requirements
- R1: After reset, `ready` is 1, `status` is 0x80, `rd_array` is 1 and `eng_pause_req` is 0. Status bit positions are: bit 7 ready, bit 4 program error, bit 3 voltage error, bit 2 suspended; all other bits read 0.
- R2: A write of the setup code (default 0x40) followed by any second write launches a program. In the cycle after the second write, `eng_start` is 1 for exactly one cycle, `eng_addr`/`eng_data` hold that write's address and data, `ready` is 0, `status` is 0x00 (the error bits are cleared) and `rd_array` is 0.
- R3: A suspend code (default 0xB0) written while a program is running raises `eng_pause_req` in the next cycle and selects status reads from that cycle on. `ready` stays 0 and status bit 2 stays 0 until the engine acknowledges the pause.
- R4: Once `eng_paused` is seen, `ready` is 1 and `status` reads 0x84 (bits 7 and 2 set), while `eng_pause_req` stays high.
- R5: While suspended, only read array (0xFF), read status (0x70) and resume (0xD0) take effect. Any other code (for example 0x40, 0x20 or 0xB0) leaves `status`, `ready` and `rd_array` unchanged.
- R6: While suspended in read-array mode, `rd_array` is 0 whenever `rd_addr` equals the address of the suspended program, compared above `GUARD_LSB` bits. For any other address it is 1.
- R7: A resume code while suspended drops `eng_pause_req`, clears status bits 7 and 2 (`status` becomes 0x00) and makes `ready` 0, all in the next cycle. It also selects status reads.
- R8: If `vpp_ok` or `rst_hv` differs during suspend from its value at program start, then in the next cycle `eng_abort` pulses for one cycle, the pause request drops, `ready` is 1 and `status` reads 0x98 (bits 7, 4 and 3).
- R9: A suspend code written while no program is running is ignored, except that it selects status reads: `eng_pause_req` stays 0 and `status` stays 0x80.
- R10: The paused acknowledge arrives no more than `MAX_PAUSE_LAT` clocks after the pause request is raised.
- R11: While a program runs, codes other than suspend are ignored and reads stay on status. After `eng_done`, `ready` is 1, `status` is 0x80 and reads remain on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | DW | Command or program data byte |
| cmd_addr | input | AW | Command or program address |
| rd_addr | input | AW | Address of the current host read |
| vpp_ok | input | 1 | Programming-supply-valid qualifier |
| rst_hv | input | 1 | Reset-pin-at-high-level qualifier |
| eng_paused | input | 1 | Engine has halted at its safe point |
| eng_done | input | 1 | Engine finished the program (one-cycle pulse) |
| eng_start | output | 1 | Launch pulse to the engine |
| eng_pause_req | output | 1 | Pause request to the engine |
| eng_abort | output | 1 | Abandon pulse to the engine |
| eng_addr | output | AW | Latched program address |
| eng_data | output | DW | Latched program data |
| ready | output | 1 | Ready (1) / busy (0) |
| status | output | 8 | Status byte |
| rd_array | output | 1 | Read path select: 1 array, 0 status |

## Verification
The bench pauses a running program and checks the cycle before the engine acknowledges. A design that showed the suspended state early would report ready while the engine was still writing. In suspend it reads both the paused address and a neighbouring one; a design without the address guard would return half-programmed array data. It sends codes that are not allowed in suspend, so a design that decoded them would fall out of the suspended state or change its read mode. It also changes each qualifier during suspend, where a design that failed to abandon the operation would leave the engine parked with no error reported.

// File: rtl/psq_pkg.sv
package psq_pkg;
   localparam int SR_W      = 8;
   localparam int SR_READY  = 7;
   localparam int SR_PERR   = 4;
   localparam int SR_VERR   = 3;
   localparam int SR_SUSP   = 2;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_SETUP,
      PS_BUSY,
      PS_PAUSING,
      PS_SUSP
   } psq_state_e;

   typedef enum logic [2:0] {
      CMD_OTHER,
      CMD_RDARR,
      CMD_RDSTAT,
      CMD_SETUP,
      CMD_SUSPEND,
      CMD_RESUME
   } psq_cmd_e;
endpackage

// File: rtl/psq_cmd_decode.sv
module psq_cmd_decode
   import psq_pkg::*;
#(
   parameter int              DW           = 8,
   parameter logic [DW-1:0]   CODE_RDARR   = 'hFF,
   parameter logic [DW-1:0]   CODE_RDSTAT  = 'h70,
   parameter logic [DW-1:0]   CODE_SETUP   = 'h40,
   parameter logic [DW-1:0]   CODE_SUSPEND = 'hB0,
   parameter logic [DW-1:0]   CODE_RESUME  = 'hD0
) (
   input  logic [DW-1:0] code,
   output psq_cmd_e      cmd
);
   always_comb begin
      if (code == CODE_RDARR)        cmd = CMD_RDARR;
      else if (code == CODE_RDSTAT)  cmd = CMD_RDSTAT;
      else if (code == CODE_SETUP)   cmd = CMD_SETUP;
      else if (code == CODE_SUSPEND) cmd = CMD_SUSPEND;
      else if (code == CODE_RESUME)  cmd = CMD_RESUME;
      else                           cmd = CMD_OTHER;
   end
endmodule

// File: rtl/psq_qual_mon.sv
module psq_qual_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic vpp_ok,
   input  logic rst_hv,
   output logic mismatch
);
   logic vpp_q;
   logic hv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpp_q <= 1'b0;
         hv_q  <= 1'b0;
      end else if (capture) begin
         vpp_q <= vpp_ok;
         hv_q  <= rst_hv;
      end
   end

   assign mismatch = (vpp_q != vpp_ok) || (hv_q != rst_hv);
endmodule

// File: rtl/psq_read_sel.sv
module psq_read_sel #(
   parameter int AW        = 16,
   parameter int GUARD_LSB = 0
) (
   input  logic          array_mode,
   input  logic          suspended,
   input  logic [AW-1:0] rd_addr,
   input  logic [AW-1:0] prog_addr,
   output logic          rd_array
);
   logic hit;

   generate
      if (GUARD_LSB == 0) begin : g_exact
         assign hit = (rd_addr == prog_addr);
      end else begin : g_region
         assign hit = (rd_addr[AW-1:GUARD_LSB] == prog_addr[AW-1:GUARD_LSB]);
      end
   endgenerate

   assign rd_array = array_mode && !(suspended && hit);
endmodule

// File: rtl/psq_seq.sv
module psq_seq
   import psq_pkg::*;
#(
   parameter int            DW            = 8,
   parameter int            AW            = 16,
   parameter int            GUARD_LSB     = 0,
   parameter int            MAX_PAUSE_LAT = 8,
   parameter logic [DW-1:0] CODE_RDARR    = 'hFF,
   parameter logic [DW-1:0] CODE_RDSTAT   = 'h70,
   parameter logic [DW-1:0] CODE_SETUP    = 'h40,
   parameter logic [DW-1:0] CODE_SUSPEND  = 'hB0,
   parameter logic [DW-1:0] CODE_RESUME   = 'hD0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic [DW-1:0] cmd_data,
   input  logic [AW-1:0] cmd_addr,
   input  logic [AW-1:0] rd_addr,
   input  logic          vpp_ok,
   input  logic          rst_hv,
   input  logic          eng_paused,
   input  logic          eng_done,
   output logic          eng_start,
   output logic          eng_pause_req,
   output logic          eng_abort,
   output logic [AW-1:0] eng_addr,
   output logic [DW-1:0] eng_data,
   output logic          ready,
   output logic [7:0]    status,
   output logic          rd_array
);
   localparam int CMP_W = AW - GUARD_LSB;

   initial begin
      assert (DW >= 8) else $error("psq_seq: DW must be at least 8");
      assert (AW >= 1) else $error("psq_seq: AW must be positive");
      assert (GUARD_LSB >= 0 && CMP_W >= 1) else $error("psq_seq: GUARD_LSB out of range");
      assert (MAX_PAUSE_LAT >= 1) else $error("psq_seq: MAX_PAUSE_LAT must be positive");
   end

   psq_state_e st, st_n;
   psq_cmd_e   cmd;
   logic       arr_mode, arr_mode_n;
   logic       perr, perr_n, verr, verr_n;
   logic       start_n, abort_n, capture;
   logic       qual_bad;
   logic       suspended;

   psq_cmd_decode #(
      .DW(DW), .CODE_RDARR(CODE_RDARR), .CODE_RDSTAT(CODE_RDSTAT),
      .CODE_SETUP(CODE_SETUP), .CODE_SUSPEND(CODE_SUSPEND), .CODE_RESUME(CODE_RESUME)
   ) u_dec (
      .code (cmd_data),
      .cmd  (cmd)
   );

   psq_qual_mon u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .vpp_ok   (vpp_ok),
      .rst_hv   (rst_hv),
      .mismatch (qual_bad)
   );

   always_comb begin
      st_n       = st;
      arr_mode_n = arr_mode;
      perr_n     = perr;
      verr_n     = verr;
      start_n    = 1'b0;
      abort_n    = 1'b0;
      capture    = 1'b0;
      case (st)
         PS_IDLE: begin
            if (cmd_we) begin
               case (cmd)
                  CMD_RDARR:   arr_mode_n = 1'b1;
                  CMD_RDSTAT:  arr_mode_n = 1'b0;
                  CMD_SUSPEND: arr_mode_n = 1'b0;
                  CMD_SETUP: begin
                     st_n       = PS_SETUP;
                     arr_mode_n = 1'b0;
                  end
                  default: ;
               endcase
            end
         end
         PS_SETUP: begin
            if (cmd_we) begin
               st_n       = PS_BUSY;
               start_n    = 1'b1;
               capture    = 1'b1;
               perr_n     = 1'b0;
               verr_n     = 1'b0;
               arr_mode_n = 1'b0;
            end
         end
         PS_BUSY: begin
            if (eng_done)                              st_n = PS_IDLE;
            else if (cmd_we && cmd == CMD_SUSPEND)     st_n = PS_PAUSING;
         end
         PS_PAUSING: begin
            if (eng_done)        st_n = PS_IDLE;
            else if (eng_paused) st_n = PS_SUSP;
         end
         PS_SUSP: begin
            if (qual_bad) begin
               st_n       = PS_IDLE;
               abort_n    = 1'b1;
               perr_n     = 1'b1;
               verr_n     = 1'b1;
               arr_mode_n = 1'b0;
            end else if (cmd_we) begin
               case (cmd)
                  CMD_RDARR:  arr_mode_n = 1'b1;
                  CMD_RDSTAT: arr_mode_n = 1'b0;
                  CMD_RESUME: begin
                     st_n       = PS_BUSY;
                     arr_mode_n = 1'b0;
                  end
                  default: ;
               endcase
            end
         end
         default: st_n = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= PS_IDLE;
         arr_mode  <= 1'b1;
         perr      <= 1'b0;
         verr      <= 1'b0;
         eng_start <= 1'b0;
         eng_abort <= 1'b0;
         eng_addr  <= '0;
         eng_data  <= '0;
      end else begin
         st        <= st_n;
         arr_mode  <= arr_mode_n;
         perr      <= perr_n;
         verr      <= verr_n;
         eng_start <= start_n;
         eng_abort <= abort_n;
         if (capture) begin
            eng_addr <= cmd_addr;
            eng_data <= cmd_data;
         end
      end
   end

   assign suspended     = (st == PS_SUSP);
   assign eng_pause_req = (st == PS_PAUSING) || suspended;
   assign ready         = (st == PS_IDLE) || (st == PS_SETUP) || suspended;

   always_comb begin
      status           = '0;
      status[SR_READY] = ready;
      status[SR_PERR]  = perr;
      status[SR_VERR]  = verr;
      status[SR_SUSP]  = suspended;
   end

   psq_read_sel #(.AW(AW), .GUARD_LSB(GUARD_LSB)) u_rsel (
      .array_mode (arr_mode),
      .suspended  (suspended),
      .rd_addr    (rd_addr),
      .prog_addr  (eng_addr),
      .rd_array   (rd_array)
   );
endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk #(
   parameter int            DW            = 8,
   parameter int            AW            = 16,
   parameter int            GUARD_LSB     = 0,
   parameter int            MAX_PAUSE_LAT = 8,
   parameter logic [DW-1:0] CODE_SUSPEND  = 'hB0,
   parameter logic [DW-1:0] CODE_RESUME   = 'hD0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_we,
   input logic [DW-1:0] cmd_data,
   input logic [AW-1:0] rd_addr,
   input logic [AW-1:0] eng_addr,
   input logic          eng_paused,
   input logic          eng_done,
   input logic          eng_start,
   input logic          eng_pause_req,
   input logic          eng_abort,
   input logic          ready,
   input logic          sr_rdy,
   input logic          sr_perr,
   input logic          sr_verr,
   input logic          sr_susp,
   input logic          rd_array
);
   int unsigned wait_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                        wait_cnt <= 0;
      else if (eng_pause_req && !eng_paused) wait_cnt <= wait_cnt + 1;
      else                               wait_cnt <= 0;
   end

   // R10: engine acknowledge latency bound
   assert_pause_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= MAX_PAUSE_LAT);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !ready && !sr_perr && !sr_verr);

   assert_suspend_to_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data == CODE_SUSPEND && !ready && !eng_done |=> !rd_array && eng_pause_req);

   assert_suspended_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sr_susp |-> ready && sr_rdy && eng_pause_req);

   assert_guard_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sr_susp && ((rd_addr >> GUARD_LSB) == (eng_addr >> GUARD_LSB)) |-> !rd_array);

   assert_resume_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sr_susp && cmd_we && cmd_data == CODE_RESUME |=> !sr_susp && !eng_pause_req);

   assert_abort_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> sr_perr && sr_verr && ready && !eng_pause_req);

   assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> !eng_abort);
endmodule

bind psq_seq psq_seq_chk #(
   .DW(DW), .AW(AW), .GUARD_LSB(GUARD_LSB), .MAX_PAUSE_LAT(MAX_PAUSE_LAT),
   .CODE_SUSPEND(CODE_SUSPEND), .CODE_RESUME(CODE_RESUME)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_we        (cmd_we),
   .cmd_data      (cmd_data),
   .rd_addr       (rd_addr),
   .eng_addr      (eng_addr),
   .eng_paused    (eng_paused),
   .eng_done      (eng_done),
   .eng_start     (eng_start),
   .eng_pause_req (eng_pause_req),
   .eng_abort     (eng_abort),
   .ready         (ready),
   .sr_rdy        (status[7]),
   .sr_perr       (status[4]),
   .sr_verr       (status[3]),
   .sr_susp       (status[2]),
   .rd_array      (rd_array)
);

// File: tb/tb_psq_seq.sv
module tb_psq_seq;
   localparam int MAX_LAT  = 8;
   localparam int PROG_CYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_data = '0;
   logic [15:0] cmd_addr = '0;
   logic [15:0] rd_addr = '0;
   logic        vpp_ok = 1'b1;
   logic        rst_hv = 1'b0;
   logic        eng_paused, eng_done;
   logic        eng_start, eng_pause_req, eng_abort;
   logic [15:0] eng_addr;
   logic [7:0]  eng_data;
   logic        ready;
   logic [7:0]  status;
   logic        rd_array;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   psq_seq #(.MAX_PAUSE_LAT(MAX_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .cmd_addr(cmd_addr), .rd_addr(rd_addr), .vpp_ok(vpp_ok), .rst_hv(rst_hv),
      .eng_paused(eng_paused), .eng_done(eng_done), .eng_start(eng_start),
      .eng_pause_req(eng_pause_req), .eng_abort(eng_abort), .eng_addr(eng_addr),
      .eng_data(eng_data), .ready(ready), .status(status), .rd_array(rd_array)
   );

   // abstract program engine: halts only when its counter sits on a multiple of 4
   int  eng_cnt;
   bit  eng_run;
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_run <= 1'b0; eng_paused <= 1'b0; eng_done <= 1'b0; eng_cnt <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_abort) begin
            eng_run <= 1'b0; eng_paused <= 1'b0;
         end else if (eng_start) begin
            eng_run <= 1'b1; eng_cnt <= PROG_CYC;
         end else if (eng_run) begin
            if (eng_pause_req && !eng_paused && (eng_cnt % 4 == 0)) eng_paused <= 1'b1;
            else if (eng_paused && !eng_pause_req)                   eng_paused <= 1'b0;
            else if (!eng_paused) begin
               if (eng_cnt == 1) begin eng_run <= 1'b0; eng_done <= 1'b1; end
               eng_cnt <= eng_cnt - 1;
            end
         end
      end
   end

   typedef struct {
      bit         rdy;
      logic [7:0] sr;
      bit         arr;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   event mon_ev;

   task automatic drain();
      while (exp_q.size() > 0) begin
         exp_t it = exp_q.pop_front();
         checks++;
         if (ready !== it.rdy || status !== it.sr || rd_array !== it.arr) begin
            errors++;
            $display("FAIL %s: actual ready=%0b status=%02h rd_array=%0b expected ready=%0b status=%02h rd_array=%0b",
                     it.tag, ready, status, rd_array, it.rdy, it.sr, it.arr);
         end
      end
   endtask

   initial forever begin
      @(mon_ev);
      drain();
   end

   task automatic expect_out(input bit r, input logic [7:0] s, input bit a, input string tag);
      exp_t it;
      it.rdy = r; it.sr = s; it.arr = a; it.tag = tag;
      exp_q.push_back(it);
      -> mon_ev;
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d, input logic [15:0] a);
      cmd_data = d; cmd_addr = a; cmd_we = 1'b1;
      step();
      cmd_we = 1'b0;
   endtask

   task automatic wait_ready(output int lat);
      lat = 1;
      while (!ready && lat < 100) begin step(); lat++; end
   endtask

   task automatic start_prog(input logic [7:0] d, input logic [15:0] a);
      wr(8'h40, 16'h0);
      wr(d, a);
   endtask

   task automatic finish_run();
      #1 drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      expect_out(1'b1, 8'h80, 1'b1, "R1 reset state");
      chk("R1 no pause request", 32'(eng_pause_req), 32'h0);

      wr(8'hB0, 16'h0);
      expect_out(1'b1, 8'h80, 1'b0, "R9 suspend while idle");
      chk("R9 no pause request", 32'(eng_pause_req), 32'h0);

      wr(8'hFF, 16'h0);
      expect_out(1'b1, 8'h80, 1'b1, "R1 read array restored");

      wr(8'h40, 16'h0);
      expect_out(1'b1, 8'h80, 1'b0, "R2 setup selects status");
      wr(8'h5A, 16'h0012);
      chk("R2 start pulse", 32'(eng_start), 32'h1);
      chk("R2 latched addr", 32'(eng_addr), 32'h12);
      chk("R2 latched data", 32'(eng_data), 32'h5A);
      expect_out(1'b0, 8'h00, 1'b0, "R2 busy after launch");
      step();
      chk("R2 start single cycle", 32'(eng_start), 32'h0);

      wr(8'hFF, 16'h0);
      expect_out(1'b0, 8'h00, 1'b0, "R11 read array ignored while busy");

      wr(8'hB0, 16'h0);
      chk("R3 pause request raised", 32'(eng_pause_req), 32'h1);
      expect_out(1'b0, 8'h00, 1'b0, "R3 busy before acknowledge");
      wait_ready(lat);
      chk("R10 pause latency within bound", 32'(lat <= MAX_LAT), 32'h1);
      expect_out(1'b1, 8'h84, 1'b0, "R4 suspended status");
      chk("R4 pause request held", 32'(eng_pause_req), 32'h1);

      wr(8'h40, 16'h0);
      expect_out(1'b1, 8'h84, 1'b0, "R5 setup ignored in suspend");
      wr(8'hFF, 16'h0);
      rd_addr = 16'h0013; #1;
      expect_out(1'b1, 8'h84, 1'b1, "R6 other address reads array");
      rd_addr = 16'h0012; #1;
      expect_out(1'b1, 8'h84, 1'b0, "R6 suspended address blocked");
      rd_addr = 16'h0013; #1;
      wr(8'h20, 16'h0);
      expect_out(1'b1, 8'h84, 1'b1, "R5 unknown code ignored");
      wr(8'hB0, 16'h0);
      expect_out(1'b1, 8'h84, 1'b1, "R5 repeated suspend ignored");
      wr(8'h70, 16'h0);
      expect_out(1'b1, 8'h84, 1'b0, "R5 read status accepted");

      wr(8'hD0, 16'h0);
      expect_out(1'b0, 8'h00, 1'b0, "R7 resume clears flags");
      chk("R7 pause request dropped", 32'(eng_pause_req), 32'h0);
      wait_ready(lat);
      expect_out(1'b1, 8'h80, 1'b0, "R11 done returns ready");

      start_prog(8'h33, 16'h0040);
      wr(8'hB0, 16'h0);
      wait_ready(lat);
      expect_out(1'b1, 8'h84, 1'b0, "R4 second suspend");
      vpp_ok = 1'b0;
      step();
      chk("R8 abort pulse on supply change", 32'(eng_abort), 32'h1);
      chk("R8 pause request dropped", 32'(eng_pause_req), 32'h0);
      expect_out(1'b1, 8'h98, 1'b0, "R8 supply change errors");
      step();
      chk("R8 abort single cycle", 32'(eng_abort), 32'h0);
      vpp_ok = 1'b1;

      start_prog(8'h77, 16'h0080);
      expect_out(1'b0, 8'h00, 1'b0, "R2 new program clears errors");
      wr(8'hB0, 16'h0);
      wait_ready(lat);
      rst_hv = 1'b1;
      step();
      chk("R8 abort pulse on reset-level change", 32'(eng_abort), 32'h1);
      expect_out(1'b1, 8'h98, 1'b0, "R8 reset-level change errors");
      rst_hv = 1'b0;

      repeat (3) step();
      finish_run();
   end
endmodule